// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Slice with Up/Down Counter and Shifter

This block multiplies two signed 18-bit operands and applies the 36-bit product to a 48-bit accumulator register. A 3-bit mode input chooses what happens to the accumulator: it can be cleared, loaded with the product, or accumulated with the product. It can also count up or down by one, or be loaded with operand A shifted left. The shift reuses the multiplier by substituting a power of two for operand B. Any operation with the valid input low does nothing.

Two optional register stages sit in the pipeline. One is on the operands and one is on the product. Each one adds a cycle of latency and shortens the combinational path. The accumulator register is always present. A valid bit travels down the pipeline next to the data, so every accepted operation produces one output-valid pulse a fixed number of cycles later. After an operation's pulse, the accumulator output shows the result of that operation.

Top module: `mac_count_slice`

## Requirements
- R1: Mode 010 with the valid input high loads the accumulator with the signed product A×B, sign-extended from 36 to 48 bits.
- R2: Mode 011 adds the sign-extended signed product to the accumulator, wrapping modulo 2^48. Back-to-back accumulates each see the previous result.
- R3: Mode 001 sets the accumulator to zero.
- R4: Mode 100 increments the accumulator by one, and all ones wraps to zero.
- R5: Mode 101 decrements the accumulator by one, and zero wraps to all ones.
- R6: Mode 110 loads the accumulator with A×2^s, sign-extended, where s is the shift input. Shift values above 16 are treated as 16.
- R7: Mode 000 and mode 111 leave the accumulator unchanged, but they still produce an output-valid pulse.
- R8: The output valid is high exactly LAT cycles after an accepted input, where LAT = IN_REG + PROD_REG + 1 (3 with the defaults). The accumulator shows the operation's result in that same cycle.
- R9: Inputs presented with the valid input low have no effect on the accumulator and produce no output-valid pulse.
- R10: A synchronous active-high reset clears the accumulator and the output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation valid |
| in_mode | input | 3 | Operation mode |
| in_a | input | 18 | Signed operand A |
| in_b | input | 18 | Signed operand B |
| in_shift | input | 5 | Left shift amount for mode 110 |
| out_valid | output | 1 | Result valid |
| out_acc | output | 48 | Accumulator value |

## Verification
The embedded assertions check the following on every cycle: the per-mode accumulator updates (clear, count up, count down, accumulate), holding when no operation reaches the last stage, the one-hot shift operand, and the last pipeline stage of valid timing. Only the bench's scenarios can show the complete latency from input to output, the wrap-around corners of the counter, and the clamping of large shift amounts. The same applies to signed products with every sign combination and to inputs with the valid low being ignored. The bench checks these against a reference model and a queue of expected results that are due at a specific cycle.

// File: rtl/mac_count_slice.sv
module mac_count_slice #(
  parameter int A_W      = 18,
  parameter int B_W      = 18,
  parameter int ACC_W    = 48,
  parameter int SH_W     = 5,
  parameter int SH_MAX   = 16,
  parameter int IN_REG   = 1,
  parameter int PROD_REG = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              in_mode,
  input  logic signed [A_W-1:0]   in_a,
  input  logic signed [B_W-1:0]   in_b,
  input  logic [SH_W-1:0]         in_shift,
  output logic                    out_valid,
  output logic [ACC_W-1:0]        out_acc
);

  localparam int P_W = A_W + B_W;
  localparam int LAT = IN_REG + PROD_REG + 1;
  localparam logic [SH_W-1:0] SH_LIM = SH_W'(SH_MAX);

  localparam logic [2:0] MD_IDLE  = 3'b000;
  localparam logic [2:0] MD_CLR   = 3'b001;
  localparam logic [2:0] MD_LOAD  = 3'b010;
  localparam logic [2:0] MD_ACC   = 3'b011;
  localparam logic [2:0] MD_UP    = 3'b100;
  localparam logic [2:0] MD_DN    = 3'b101;
  localparam logic [2:0] MD_SHIFT = 3'b110;

  // operand stage
  logic                  v1;
  logic [2:0]            m1;
  logic signed [A_W-1:0] a1;
  logic signed [B_W-1:0] b1;
  logic [SH_W-1:0]       s1;

  generate
    if (IN_REG != 0) begin : g_in_reg
      always_ff @(posedge clk) begin
        if (rst) v1 <= 1'b0;
        else     v1 <= in_valid;
        m1 <= in_mode;
        a1 <= in_a;
        b1 <= in_b;
        s1 <= in_shift;
      end
    end else begin : g_in_wire
      assign v1 = in_valid;
      assign m1 = in_mode;
      assign a1 = in_a;
      assign b1 = in_b;
      assign s1 = in_shift;
    end
  endgenerate

  logic [SH_W-1:0]       s_clamp;
  logic signed [B_W-1:0] b_hot;
  logic signed [B_W-1:0] b_eff;
  logic signed [P_W-1:0] prod_c;

  assign s_clamp = (s1 > SH_LIM) ? SH_LIM : s1;
  assign b_hot   = B_W'(1) << s_clamp;
  assign b_eff   = (m1 == MD_SHIFT) ? b_hot : b1;
  assign prod_c  = a1 * b_eff;

  // product stage
  logic                  v2;
  logic [2:0]            m2;
  logic signed [P_W-1:0] p2;

  generate
    if (PROD_REG != 0) begin : g_prod_reg
      always_ff @(posedge clk) begin
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
        m2 <= m1;
        p2 <= prod_c;
      end
    end else begin : g_prod_wire
      assign v2 = v1;
      assign m2 = m1;
      assign p2 = prod_c;
    end
  endgenerate

  logic [ACC_W-1:0] p_ext;
  assign p_ext = {{(ACC_W-P_W){p2[P_W-1]}}, p2};

  // accumulator stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_acc   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        case (m2)
          MD_CLR:            out_acc <= '0;
          MD_LOAD, MD_SHIFT: out_acc <= p_ext;
          MD_ACC:            out_acc <= out_acc + p_ext;
          MD_UP:             out_acc <= out_acc + ACC_W'(1);
          MD_DN:             out_acc <= out_acc - ACC_W'(1);
          default:           out_acc <= out_acc;
        endcase
      end
    end
  end

  AST_VALID_STAGE: assert property (@(posedge clk) disable iff (rst)
    v2 |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !v2 |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!v2 || m2 == MD_IDLE || m2 == 3'b111) |=> $stable(out_acc)); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (v2 && m2 == MD_CLR) |=> (out_acc == '0)); // R3
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (v2 && m2 == MD_UP) |=> (out_acc - $past(out_acc) == ACC_W'(1))); // R4
  AST_COUNT_DN: assert property (@(posedge clk) disable iff (rst)
    (v2 && m2 == MD_DN) |=> ($past(out_acc) - out_acc == ACC_W'(1))); // R5
  AST_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (v2 && m2 == MD_ACC) |=> (out_acc - $past(out_acc) == $past(p_ext))); // R2
  AST_SHIFT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (v1 && m1 == MD_SHIFT) |-> ($onehot0(b_eff) && !b_eff[B_W-1])); // R6
  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (v1 && m1 == MD_SHIFT) |-> (s_clamp <= SH_LIM)); // R6

  initial assert (LAT >= 1 && SH_MAX < B_W - 1);

endmodule

// File: tb/mac_count_slice_bench.sv
module mac_count_slice_bench;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_mode = 3'b000;
  logic signed [17:0] in_a = '0;
  logic signed [17:0] in_b = '0;
  logic [4:0] in_shift = '0;
  logic out_valid;
  logic [47:0] out_acc;

  always #2 clk = ~clk;

  mac_count_slice u_mac_count_slice (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .in_shift(in_shift),
    .out_valid(out_valid), .out_acc(out_acc)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [47:0] model = '0;
  logic [47:0] q_acc[$];
  int q_due[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: present one accepted operation and push its expected result
  task automatic issue(input logic [2:0] md, input logic signed [17:0] a,
                       input logic signed [17:0] b, input logic [4:0] sh, input string tag);
    longint p;
    int s;
    s = (sh > 16) ? 16 : int'(sh);
    if (md == 3'b110) p = longint'(a) * (longint'(1) <<< s);
    else              p = longint'(a) * longint'(b);
    case (md)
      3'b001: model = '0;
      3'b010, 3'b110: model = p[47:0];
      3'b011: model = model + p[47:0];
      3'b100: model = model + 48'd1;
      3'b101: model = model - 48'd1;
      default: model = model;
    endcase
    in_valid = 1'b1; in_mode = md; in_a = a; in_b = b; in_shift = sh;
    q_acc.push_back(model);
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_mode = 3'b011; in_a = 18'sd1000; in_b = 18'sd777; in_shift = 5'd3;
      @(negedge clk);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_acc.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", out_acc, '0);
      end else begin
        logic [47:0] e;
        int d;
        string t;
        e = q_acc.pop_front();
        d = q_due.pop_front();
        t = q_tag.pop_front();
        check(cyc == d, "R8 latency", 48'(cyc), 48'(d));
        check(out_acc == e, t, out_acc, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset valid", 48'(out_valid), 48'd0);
    check(out_acc == '0, "R10 reset acc", out_acc, '0);
    rst = 1'b0;
    @(negedge clk);

    issue(3'b010, 18'sd300, -18'sd7, 5'd0, "R1 load neg product");
    issue(3'b010, -18'sd131072, -18'sd131072, 5'd0, "R1 load max product");
    issue(3'b011, 18'sd1234, 18'sd5678, 5'd0, "R2 accumulate");
    issue(3'b011, -18'sd999, 18'sd321, 5'd0, "R2 accumulate back to back");
    issue(3'b011, 18'sd131071, -18'sd131072, 5'd0, "R2 accumulate signed");
    issue(3'b000, 18'sd5, 18'sd5, 5'd0, "R7 idle hold");
    issue(3'b111, 18'sd5, 18'sd5, 5'd0, "R7 code 111 hold");
    issue(3'b001, 18'sd9, 18'sd9, 5'd0, "R3 clear");
    issue(3'b101, 18'sd0, 18'sd0, 5'd0, "R5 count down wrap from zero");
    issue(3'b101, 18'sd0, 18'sd0, 5'd0, "R5 count down");
    issue(3'b100, 18'sd0, 18'sd0, 5'd0, "R4 count up");
    issue(3'b100, 18'sd0, 18'sd0, 5'd0, "R4 count up wrap to zero");
    issue(3'b100, 18'sd0, 18'sd0, 5'd0, "R4 count up from zero");
    issue(3'b110, 18'sd3, 18'sd0, 5'd0, "R6 shift zero");
    issue(3'b110, 18'sd3, 18'sd0, 5'd7, "R6 shift seven");
    issue(3'b110, -18'sd131072, 18'sd0, 5'd16, "R6 shift max negative");
    issue(3'b110, 18'sd5, 18'sd0, 5'd25, "R6 shift clamp");
    issue(3'b110, -18'sd1, 18'sd0, 5'd31, "R6 shift clamp negative");
    junk(6);
    issue(3'b000, 18'sd0, 18'sd0, 5'd0, "R9 invalid inputs ignored");
    junk(2);
    issue(3'b011, -18'sd1, 18'sd1, 5'd0, "R2 accumulate after gap");

    repeat (LAT + 4) @(negedge clk);
    check(q_acc.size() == 0, "R8 all results delivered", 48'(q_acc.size()), '0);
    finish_run();
  end
endmodule